// File: doc/BRIEF.md
# Triggered Event Builder

After each accepted trigger, this block gathers the 32-bit time and charge words waiting in a set of per-channel buffers. It frames them as one event and stores the event in a 64-bit-wide output FIFO, where a bus master reads it out. An event opens with a header that carries an 8-bit trigger number and closes with a trailer that holds the number of data words. The data words between them are packed two to a FIFO entry.

The channel buffers are visited in ascending index order. Time buffers sit on the low indices, so time words always come before charge words. Each channel ends its share of an event with a beat marked last; a last beat with its keep bit clear contributes no word. A registered hold-off flag tells the trigger source to pause when the FIFO cannot take another full-size event. The flag uses hysteresis, so it does not toggle on every read.

Top module: `event_builder`

## Requirements
- R1: A trigger accepted while the block is idle advances an 8-bit trigger number held in the block. That number is 0 after reset, so the first event is number 1, and it wraps from 255 to 0. The new value appears in bits [7:0] of that event's header.
- R2: A header entry has 8'hE0 in bits [63:56] and zero in bits [55:8].
- R3: A trailer entry has 8'hF0 in bits [63:56], the event's data-word count in bits [15:0], and zero elsewhere.
- R4: Data words are stored in channel index order, and within one channel in arrival order. Of each pair, the earlier word goes into bits [31:0] and the later word into bits [63:32].
- R5: When an event has an odd number of data words, bits [63:32] of its last data entry hold 32'hFFFF_FFFF.
- R6: A last beat whose keep bit is low adds no word. An event with no data words is exactly a header followed by a trailer.
- R7: A trigger that arrives while an event is being built is ignored. It creates no entries and does not change the trigger number.
- R8: Only the channel currently being collected sees ready high. At most one ready is high at a time, and none is high while idle.
- R9: When rd_en_i is high and the FIFO is not empty, the oldest entry appears on rd_data_o in the next cycle. empty_o is high exactly when no entries are stored, including after reset. A read request while empty has no effect.
- R10: hold_o rises one cycle after the occupancy exceeds DEPTH minus (2 + ceil(MAX_WORDS/2)). It is low after reset.
- R11: Once raised, hold_o stays high until the occupancy falls below DEPTH/2, and it drops one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger pulse |
| ch_valid_i | input | NUM_CH | Per-channel beat valid |
| ch_keep_i | input | NUM_CH | Beat carries a data word |
| ch_last_i | input | NUM_CH | Final beat of this channel for the event |
| ch_data_i | input | NUM_CH*32 | Per-channel 32-bit words, channel 0 in the low bits |
| ch_ready_o | output | NUM_CH | Per-channel beat accept |
| rd_en_i | input | 1 | FIFO read request |
| rd_data_o | output | 64 | FIFO read data, one cycle after the request |
| empty_o | output | 1 | FIFO holds no entries |
| hold_o | output | 1 | Trigger hold-off flag |

## Verification
The bench runs events with odd and even word counts, channels with no data, and an event with no data at all. A packer that swapped halves, dropped the pad word, or counted keep-less beats would show wrong entries or a wrong trailer count. A trigger is pulsed in the middle of an event: a design that accepted it would add a header or skip a trigger number. The bench runs the trigger number through the 255-to-0 wrap, which an off-by-one or wider counter would get wrong. It also walks the FIFO occupancy across both hold-off thresholds, which would expose a flag that lacked hysteresis or released one entry early.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int WORD_W = 32;
  localparam int ENTRY_W = 64;
  localparam logic [7:0] HDR_CODE = 8'hE0;
  localparam logic [7:0] TRL_CODE = 8'hF0;
  localparam logic [WORD_W-1:0] PAD_WORD = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    S_IDLE,
    S_COLLECT,
    S_PAD,
    S_TRL
  } eb_state_t;
endpackage

// File: rtl/eb_fifo.sv
module eb_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 2048
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [WIDTH-1:0]           wr_data_i,
  input  logic                       rd_en_i,
  output logic [WIDTH-1:0]           rd_data_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH):0]     count_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic do_wr, do_rd;

  assign do_wr   = wr_en_i && (count != CW'(DEPTH));
  assign do_rd   = rd_en_i && (count != '0);
  assign empty_o = (count == '0);
  assign count_o = count;

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data_i;
    if (do_rd) rd_data_o <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_write_fills_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !rd_en_i && empty_o) |=> !empty_o);
  assert_empty_read_inert_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && empty_o && !wr_en_i) |=> (empty_o && $stable(rd_data_o)));
endmodule

// File: rtl/eb_throttle.sv
module eb_throttle #(
  parameter int CNT_W = 12,
  parameter int HIGH_MARK = 2000,
  parameter int LOW_MARK = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  output logic             hold_o
);
  always_ff @(posedge clk) begin
    if (rst) hold_o <= 1'b0;
    else if (hold_o) hold_o <= (count_i >= CNT_W'(LOW_MARK));
    else hold_o <= (count_i > CNT_W'(HIGH_MARK));
  end

  assert_hold_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_o) |-> ($past(count_i) > CNT_W'(HIGH_MARK)));
  assert_hold_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_o) |-> ($past(count_i) < CNT_W'(LOW_MARK)));
endmodule

// File: rtl/eb_assembler.sv
module eb_assembler
  import eb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int MAX_WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trig_i,
  input  logic [NUM_CH-1:0]        ch_valid_i,
  input  logic [NUM_CH-1:0]        ch_keep_i,
  input  logic [NUM_CH-1:0]        ch_last_i,
  input  logic [NUM_CH*WORD_W-1:0] ch_data_i,
  output logic [NUM_CH-1:0]        ch_ready_o,
  output logic                     wr_en_o,
  output logic [ENTRY_W-1:0]       wr_data_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int NW_W = $clog2(MAX_WORDS + 1);

  eb_state_t state;
  logic [CH_W-1:0] ch_sel;
  logic [7:0] trig_num;
  logic [NW_W-1:0] n_words;
  logic half_full;
  logic [WORD_W-1:0] low_hold;
  logic [WORD_W-1:0] cur_data;
  logic cur_valid, cur_keep, cur_last;

  always_comb begin
    cur_data  = ch_data_i[int'(ch_sel)*WORD_W +: WORD_W];
    cur_valid = ch_valid_i[ch_sel];
    cur_keep  = ch_keep_i[ch_sel];
    cur_last  = ch_last_i[ch_sel];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ready
    assign ch_ready_o[g] = (state == S_COLLECT) && (ch_sel == CH_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ch_sel    <= '0;
      trig_num  <= '0;
      n_words   <= '0;
      half_full <= 1'b0;
      low_hold  <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      case (state)
        S_IDLE: if (trig_i) begin
          trig_num  <= trig_num + 8'd1;
          wr_en_o   <= 1'b1;
          wr_data_o <= {HDR_CODE, 48'h0, trig_num + 8'd1};
          ch_sel    <= '0;
          n_words   <= '0;
          half_full <= 1'b0;
          state     <= S_COLLECT;
        end
        S_COLLECT: if (cur_valid) begin
          if (cur_keep) begin
            n_words <= n_words + 1'b1;
            if (half_full) begin
              wr_en_o   <= 1'b1;
              wr_data_o <= {cur_data, low_hold};
              half_full <= 1'b0;
            end else begin
              low_hold  <= cur_data;
              half_full <= 1'b1;
            end
          end
          if (cur_last) begin
            if (ch_sel == CH_W'(NUM_CH - 1)) state <= S_PAD;
            else ch_sel <= ch_sel + 1'b1;
          end
        end
        S_PAD: begin
          if (half_full) begin
            wr_en_o   <= 1'b1;
            wr_data_o <= {PAD_WORD, low_hold};
            half_full <= 1'b0;
          end
          state <= S_TRL;
        end
        S_TRL: begin
          wr_en_o   <= 1'b1;
          wr_data_o <= {TRL_CODE, 40'h0, 16'(n_words)};
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_header_number_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && trig_i) |=> (wr_en_o && wr_data_o[7:0] == $past(trig_num) + 8'd1));
  assert_busy_trigger_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> $stable(trig_num));
  assert_single_ready_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_ready_o));
  assert_trailer_code_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_TRL) |=> (wr_en_o && wr_data_o[63:56] == TRL_CODE));
endmodule

// File: rtl/event_builder.sv
module event_builder
  import eb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int MAX_WORDS = 16,
  parameter int DEPTH = 2048
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trig_i,
  input  logic [NUM_CH-1:0]        ch_valid_i,
  input  logic [NUM_CH-1:0]        ch_keep_i,
  input  logic [NUM_CH-1:0]        ch_last_i,
  input  logic [NUM_CH*WORD_W-1:0] ch_data_i,
  output logic [NUM_CH-1:0]        ch_ready_o,
  input  logic                     rd_en_i,
  output logic [ENTRY_W-1:0]       rd_data_o,
  output logic                     empty_o,
  output logic                     hold_o
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int MAX_ENTRIES = 2 + (MAX_WORDS + 1) / 2;
  localparam int HIGH_MARK = DEPTH - MAX_ENTRIES;
  localparam int LOW_MARK = DEPTH / 2;

  logic wr_en;
  logic [ENTRY_W-1:0] wr_data;
  logic [CNT_W-1:0] fill;

  eb_assembler #(.NUM_CH(NUM_CH), .MAX_WORDS(MAX_WORDS)) u_asm (
    .clk(clk), .rst(rst), .trig_i(trig_i),
    .ch_valid_i(ch_valid_i), .ch_keep_i(ch_keep_i), .ch_last_i(ch_last_i),
    .ch_data_i(ch_data_i), .ch_ready_o(ch_ready_o),
    .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  eb_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .empty_o(empty_o), .count_o(fill)
  );

  eb_throttle #(.CNT_W(CNT_W), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) u_thr (
    .clk(clk), .rst(rst), .count_i(fill), .hold_o(hold_o)
  );
endmodule

// File: tb/event_builder_test.sv
module event_builder_test;
  localparam int NCH = 3;
  localparam int MAXW = 8;
  localparam int DEPTH = 32;
  localparam int NVEC = 9;
  // {words ch0, words ch1, words ch2, expected entries}
  localparam logic [15:0] VEC [NVEC] = '{16'h0002, 16'h1003, 16'h1103, 16'h2315,
                                         16'h0013, 16'h3025, 16'h4406, 16'h0536, 16'h1225};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic trig = 1'b0;
  logic rd_en = 1'b0;
  logic v_arr [NCH];
  logic k_arr [NCH];
  logic l_arr [NCH];
  logic [31:0] d_arr [NCH];
  logic [NCH-1:0] vv, kk, ll, rdy;
  logic [NCH*32-1:0] dd;
  logic [63:0] rd_data;
  logic empty, hold;

  assign vv = {v_arr[2], v_arr[1], v_arr[0]};
  assign kk = {k_arr[2], k_arr[1], k_arr[0]};
  assign ll = {l_arr[2], l_arr[1], l_arr[0]};
  assign dd = {d_arr[2], d_arr[1], d_arr[0]};

  event_builder #(.NUM_CH(NCH), .MAX_WORDS(MAXW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .trig_i(trig), .ch_valid_i(vv), .ch_keep_i(kk),
    .ch_last_i(ll), .ch_data_i(dd), .ch_ready_o(rdy), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty), .hold_o(hold)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] tnum = 8'd0;
  logic [63:0] exp_q [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [7:0] t, input int c, input int i);
    return {t, 8'(c), 8'h5A, 8'(i)};
  endfunction

  task automatic feed_ch(input int c, input int n);
    int nb;
    nb = (n == 0) ? 1 : n;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      v_arr[c] = 1'b1;
      k_arr[c] = (n != 0);
      l_arr[c] = (i == nb - 1);
      d_arr[c] = word_of(tnum, c, i);
      while (!rdy[c]) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    v_arr[c] = 1'b0;
  endtask

  task automatic send_event(input int n0, input int n1, input int n2);
    logic [31:0] words [$];
    int cnt [NCH];
    cnt[0] = n0; cnt[1] = n1; cnt[2] = n2;
    tnum = tnum + 8'd1;
    exp_q.push_back({8'hE0, 48'h0, tnum});
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < cnt[c]; i++) words.push_back(word_of(tnum, c, i));
    for (int i = 0; i < words.size(); i += 2) begin
      if (i + 1 < words.size()) exp_q.push_back({words[i+1], words[i]});
      else exp_q.push_back({32'hFFFF_FFFF, words[i]});
    end
    exp_q.push_back({8'hF0, 40'h0, 16'(words.size())});
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    check(rdy == 3'b001, "R8 first channel ready", 64'(rdy), 64'(3'b001));
    fork
      feed_ch(0, n0);
      feed_ch(1, n1);
      feed_ch(2, n2);
    join
    repeat (4) @(negedge clk);
  endtask

  task automatic read_cmp(input string req);
    logic [63:0] e;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hX;
    check(exp_q.size() >= 0 && rd_data === e, req, rd_data, e);
  endtask

  task automatic drain_check(input string req, input int exp_n);
    int got = 0;
    forever begin
      @(negedge clk);
      if (empty) break;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      got++;
      begin
        logic [63:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hX;
        check(rd_data === e, req, rd_data, e);
      end
    end
    if (exp_n >= 0) check(got == exp_n, {req, " entry count"}, 64'(got), 64'(exp_n));
    check(exp_q.size() == 0, {req, " leftover expected"}, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      v_arr[c] = 1'b0; k_arr[c] = 1'b0; l_arr[c] = 1'b0; d_arr[c] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(empty == 1'b1, "R9 empty after reset", 64'(empty), 64'd1);
    check(hold == 1'b0, "R10 hold low after reset", 64'(hold), 64'd0);
    check(rdy == '0, "R8 no ready while idle", 64'(rdy), 64'd0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      send_event(int'(VEC[i][15:12]), int'(VEC[i][11:8]), int'(VEC[i][7:4]));
      drain_check("R1 R2 R3 R4 R5 R6 event contents", int'(VEC[i][3:0]));
    end

    // R7: trigger in the middle of an event
    fork
      send_event(3, 2, 2);
      begin
        repeat (5) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
      end
    join
    drain_check("R7 busy trigger ignored", 6);
    send_event(1, 0, 0);
    drain_check("R7 number after ignored trigger", 3);

    // R9: read request while empty
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
    check(empty == 1'b1, "R9 empty read inert", 64'(empty), 64'd1);
    send_event(0, 2, 1);
    drain_check("R9 order after empty read", 4);

    // R1: run the trigger number through 255 -> 0
    for (int i = 0; i < 256; i++) begin
      send_event(0, 0, 0);
      drain_check("R1 wrap", 2);
    end

    // R10 / R11: hold-off thresholds (high 26, low 16)
    for (int i = 0; i < 4; i++) send_event(4, 4, 0);
    repeat (2) @(negedge clk);
    check(hold == 1'b0, "R10 hold low at 24 entries", 64'(hold), 64'd0);
    send_event(4, 4, 0);
    repeat (2) @(negedge clk);
    check(hold == 1'b1, "R10 hold high at 30 entries", 64'(hold), 64'd1);
    for (int i = 0; i < 14; i++) read_cmp("R9 R11 read during hold");
    repeat (2) @(negedge clk);
    check(hold == 1'b1, "R11 hold kept at 16 entries", 64'(hold), 64'd1);
    read_cmp("R9 R11 read during hold");
    repeat (2) @(negedge clk);
    check(hold == 1'b0, "R11 hold released at 15 entries", 64'(hold), 64'd0);
    drain_check("R11 remaining entries", 15);

    report();
  end
endmodule